// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block gathers a parameterised number of level-sensitive interrupt inputs (96 or 128, in banks of 32) and raises a single interrupt request towards a processor. Each input has an 8-bit level register whose upper six bits set its priority, and a mask bit held in a per-bank mask word. A 32-bit register bus with combinational read data gives software access to masks, masked-pending status, the level registers, a small set of configuration words and the sorted-active register, which names the source that won the latest sort.

A state machine drives the sequence. ST_IDLE waits for any unmasked pending source (transition IDLE->SORT). ST_SORT latches the winner of a parallel priority search (SORT->HOLD) or returns to ST_IDLE if the source went away (SORT->IDLE). ST_HOLD asserts the request and keeps the active number frozen until software writes the acknowledge bit (HOLD->IDLE). A soft-reset request from any of those states enters ST_SRST (any->SRST), which holds every register at its reset value for SRST_CYCLES cycles and then returns to ST_IDLE (SRST->IDLE).

Top module: `intc_top`

## Requirements
- R1: After reset, irq is 0, every mask word (offset 0x84 + 0x20*bank) reads 0xFFFFFFFF, the status word at 0x14 reads 1, sorted-active at 0x40 reads 0, every level register and the threshold word read 0, and the revision word at 0x00 reads {REV_MAJOR in bits 7:4, REV_MINOR in bits 3:0} (0x40 by default).
- R2: A write to 0x84 + 0x20*bank replaces that mask word; writing ones at 0x88 + 0x20*bank clears those mask bits (enables sources); writing ones at 0x8C + 0x20*bank sets those mask bits (disables sources); zero bits leave bits unchanged.
- R3: The word at 0x98 + 0x20*bank reads the bank's inputs ANDed with the inverse of its mask; bank addresses beyond NUM_SRC/32 read 0.
- R4: When the controller is idle and an unmasked source is high, irq rises two clock edges later, and sorted-active then reads bit 7 = 1 with the source number in bits 6:0.
- R5: The winner is the pending unmasked source with the smallest value in bits 7:2 of its level register (0 = most urgent); equal values go to the lowest source number.
- R6: While irq is high and no acknowledge is written, sorted-active and irq stay unchanged, even when a more urgent source arrives.
- R7: Writing 1 to bit 0 of the control word at 0x48 while irq is high drops irq at the next edge and lets a new sort start; this also clears an active source that was masked or removed while held.
- R8: Writing 1 to bit 1 of the config word at 0x10 drops irq, makes the status word read 0 and config bit 1 read 1 for SRST_CYCLES cycles, after which status reads 1, config bit 1 reads 0 and all registers hold their reset values.
- R9: Config bit 0 (autoidle), the protection word at 0x4C (bit 0), the idle word at 0x50 (bits 1:0) and the threshold word at 0x68 (bits 7:0) read back what was written and do not affect irq or the sort.
- R10: The level register of source n at 0x100 + 4*n stores bits 7:0 of the write and reads them back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_lvl | input | NUM_SRC | Level-sensitive interrupt inputs |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The acknowledge write and the rise of a new source can land on the same clock edge: the bench drops the held source, raises a different one and writes the acknowledge within one cycle, then expects irq low right after that edge and the new source presented two edges later. A soft-reset write can also meet an active, held source; the bench issues it while irq is high and judges that irq falls at once, the status word stays 0 for exactly SRST_CYCLES cycles and masks, levels and configuration come back at reset values. Random source and mask patterns against random, often tied priorities check the winner against a bench-side search.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SORT,
        ST_HOLD,
        ST_SRST
    } intc_state_e;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ACT_W  = 7;
    localparam int unsigned PRIO_W = 6;
    localparam int unsigned LVL_W  = 8;
    localparam int unsigned BANK_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t OFS_REV     = 12'h000;
    localparam addr_t OFS_CFG     = 12'h010;
    localparam addr_t OFS_STAT    = 12'h014;
    localparam addr_t OFS_ACTIVE  = 12'h040;
    localparam addr_t OFS_CTRL    = 12'h048;
    localparam addr_t OFS_PROT    = 12'h04C;
    localparam addr_t OFS_IDLE    = 12'h050;
    localparam addr_t OFS_THRESH  = 12'h068;
    localparam addr_t OFS_MASK0   = 12'h084;
    localparam addr_t OFS_MCLR0   = 12'h088;
    localparam addr_t OFS_MSET0   = 12'h08C;
    localparam addr_t OFS_PEND0   = 12'h098;
    localparam addr_t OFS_LVL0    = 12'h100;
    localparam int unsigned BANK_STRIDE = 32;

endpackage

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC   = 96,
    parameter int unsigned REV_MAJOR = 4,
    parameter int unsigned REV_MINOR = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      srst_busy,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [ACT_W:0]            active_word,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_SRC-1:0]        mask,
    output logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      ack_req,
    output logic                      srst_req
);

    localparam int unsigned NBANK = NUM_SRC / BANK_W;
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic              autoidle_q;
    logic              prot_q;
    logic [1:0]        idle_q;
    logic [LVL_W-1:0]  thresh_q;
    logic [LVL_W-1:0]  lvl_q [NUM_SRC];

    addr_t             lvl_off;
    logic [IDX_W-1:0]  lvl_idx;
    logic              lvl_sel;

    assign lvl_off = bus_addr - OFS_LVL0;
    assign lvl_idx = lvl_off[ADDR_W-1:2];
    assign lvl_sel = (bus_addr >= OFS_LVL0) && (bus_addr[1:0] == 2'b00)
                     && (lvl_idx < IDX_W'(NUM_SRC));

    assign ack_req  = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[0];
    assign srst_req = bus_wr && (bus_addr == OFS_CFG)  && bus_wdata[1];

    // per-bank mask words with direct, clear-by-one and set-by-one ports
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam addr_t A_MASK = OFS_MASK0 + addr_t'(b * BANK_STRIDE);
        localparam addr_t A_MCLR = OFS_MCLR0 + addr_t'(b * BANK_STRIDE);
        localparam addr_t A_MSET = OFS_MSET0 + addr_t'(b * BANK_STRIDE);
        logic [BANK_W-1:0] m_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                m_q <= '1;
            end else if (srst_busy) begin
                m_q <= '1;
            end else if (bus_wr && bus_addr == A_MASK) begin
                m_q <= bus_wdata;
            end else if (bus_wr && bus_addr == A_MCLR) begin
                m_q <= m_q & ~bus_wdata;
            end else if (bus_wr && bus_addr == A_MSET) begin
                m_q <= m_q | bus_wdata;
            end
        end

        assign mask[b*BANK_W +: BANK_W] = m_q;
    end

    // per-source level registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
        end else if (srst_busy) begin
            for (int i = 0; i < NUM_SRC; i++) lvl_q[i] <= '0;
        end else if (bus_wr && lvl_sel) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (lvl_idx == IDX_W'(i)) lvl_q[i] <= bus_wdata[LVL_W-1:0];
            end
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_prio
        assign prio_flat[s*PRIO_W +: PRIO_W] = lvl_q[s][LVL_W-1:2];
    end

    // configuration words
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= '0;
            thresh_q   <= '0;
        end else if (srst_busy) begin
            autoidle_q <= 1'b0;
            prot_q     <= 1'b0;
            idle_q     <= '0;
            thresh_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_CFG)    autoidle_q <= bus_wdata[0];
            if (bus_addr == OFS_PROT)   prot_q     <= bus_wdata[0];
            if (bus_addr == OFS_IDLE)   idle_q     <= bus_wdata[1:0];
            if (bus_addr == OFS_THRESH) thresh_q   <= bus_wdata[LVL_W-1:0];
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REV:    bus_rdata[7:0] = {REV_MAJOR[3:0], REV_MINOR[3:0]};
            OFS_CFG:    bus_rdata[1:0] = {srst_busy, autoidle_q};
            OFS_STAT:   bus_rdata[0]   = !srst_busy;
            OFS_ACTIVE: bus_rdata[ACT_W:0] = active_word;
            OFS_PROT:   bus_rdata[0]   = prot_q;
            OFS_IDLE:   bus_rdata[1:0] = idle_q;
            OFS_THRESH: bus_rdata[LVL_W-1:0] = thresh_q;
            default:    bus_rdata = '0;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == OFS_MASK0 + addr_t'(b * BANK_STRIDE))
                bus_rdata = mask[b*BANK_W +: BANK_W];
            if (bus_addr == OFS_PEND0 + addr_t'(b * BANK_STRIDE))
                bus_rdata = pend[b*BANK_W +: BANK_W];
        end
        if (lvl_sel) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (lvl_idx == IDX_W'(i)) bus_rdata = {24'h0, lvl_q[i]};
            end
        end
    end

endmodule

// File: rtl/intc_prio.sv
`timescale 1ns/1ps
module intc_prio
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    output logic                      any_pend,
    output logic [ACT_W-1:0]          win_idx
);

    logic [PRIO_W-1:0] best_p;

    // strict less-than keeps the lowest number on a tie
    always_comb begin
        any_pend = 1'b0;
        best_p   = '1;
        win_idx  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (pend[i] && (!any_pend || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
                any_pend = 1'b1;
                best_p   = prio_flat[i*PRIO_W +: PRIO_W];
                win_idx  = ACT_W'(i);
            end
        end
    end

endmodule

// File: rtl/intc_fsm.sv
`timescale 1ns/1ps
module intc_fsm
    import intc_pkg::*;
#(
    parameter int unsigned SRST_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_pend,
    input  logic [ACT_W-1:0] win_idx,
    input  logic             ack_req,
    input  logic             srst_req,
    output intc_state_e      state,
    output logic [ACT_W-1:0] active_num,
    output logic             active_vld,
    output logic             irq,
    output logic             srst_busy
);

    localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);

    intc_state_e      state_q, state_d;
    logic [CNT_W-1:0] srst_cnt;
    logic [ACT_W-1:0] act_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (srst_req && state_q != ST_SRST) begin
            state_d = ST_SRST;
        end else begin
            unique case (state_q)
                ST_IDLE: if (any_pend) state_d = ST_SORT;
                ST_SORT: state_d = any_pend ? ST_HOLD : ST_IDLE;
                ST_HOLD: if (ack_req) state_d = ST_IDLE;
                ST_SRST: if (srst_cnt == CNT_W'(SRST_CYCLES - 1)) state_d = ST_IDLE;
            endcase
        end
    end

    // soft-reset duration counter and latched winner
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            srst_cnt <= '0;
            act_q    <= '0;
        end else begin
            srst_cnt <= (state_q == ST_SRST) ? srst_cnt + 1'b1 : '0;
            if (state_d == ST_SRST)
                act_q <= '0;
            else if (state_q == ST_SORT && any_pend)
                act_q <= win_idx;
        end
    end

    // outputs
    always_comb begin
        state      = state_q;
        active_num = act_q;
        active_vld = (state_q == ST_HOLD);
        irq        = (state_q == ST_HOLD);
        srst_busy  = (state_q == ST_SRST);
    end

endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 96,
    parameter int unsigned SRST_CYCLES = 8,
    parameter int unsigned REV_MAJOR   = 4,
    parameter int unsigned REV_MINOR   = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_lvl,
    output logic               irq
);

    logic [NUM_SRC-1:0]        mask;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      any_pend;
    logic [ACT_W-1:0]          win_idx;
    logic [ACT_W-1:0]          act_num;
    logic                      act_vld;
    logic                      ack_req;
    logic                      srst_req;
    logic                      srst_busy;
    intc_state_e               st;

    assign pend = src_lvl & ~mask;

    intc_regs #(
        .NUM_SRC   (NUM_SRC),
        .REV_MAJOR (REV_MAJOR),
        .REV_MINOR (REV_MINOR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_busy   (srst_busy),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .pend        (pend),
        .active_word ({act_vld, act_num}),
        .bus_rdata   (bus_rdata),
        .mask        (mask),
        .prio_flat   (prio_flat),
        .ack_req     (ack_req),
        .srst_req    (srst_req)
    );

    intc_prio #(.NUM_SRC(NUM_SRC)) u_prio (
        .pend      (pend),
        .prio_flat (prio_flat),
        .any_pend  (any_pend),
        .win_idx   (win_idx)
    );

    intc_fsm #(.SRST_CYCLES(SRST_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_pend   (any_pend),
        .win_idx    (win_idx),
        .ack_req    (ack_req),
        .srst_req   (srst_req),
        .state      (st),
        .active_num (act_num),
        .active_vld (act_vld),
        .irq        (irq),
        .srst_busy  (srst_busy)
    );

endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [11:0]      bus_addr,
    input logic             wd0,
    input logic             wd1,
    input logic             irq,
    input intc_state_e      state,
    input logic [ACT_W-1:0] active_num,
    input logic             srst_busy
);

    logic ack_w;
    logic srst_w;
    assign ack_w  = bus_wr && bus_addr == OFS_CTRL && wd0;
    assign srst_w = bus_wr && bus_addr == OFS_CFG  && wd1;

    // R6
    held_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack_w && !srst_w) |=> (irq && $stable(active_num)));

    // R7
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack_w && !srst_w) |=> !irq);

    // R4
    active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (active_num < ACT_W'(NUM_SRC)));

    // R4
    rise_after_sort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(state) == ST_SORT));

    // R8
    srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |-> !irq);

    // R8
    srst_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_w && !srst_busy) |=> srst_busy);

endmodule

bind intc_top intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .wd0        (bus_wdata[0]),
    .wd1        (bus_wdata[1]),
    .irq        (irq),
    .state      (st),
    .active_num (act_num),
    .srst_busy  (srst_busy)
);

// File: tb/test_intc_top.sv
`timescale 1ns/1ps
module test_intc_top;

    localparam int NSRC   = 96;
    localparam int NRST   = 8;
    localparam logic [11:0] A_REV = 12'h000, A_CFG = 12'h010, A_STAT = 12'h014,
        A_ACT = 12'h040, A_CTRL = 12'h048, A_PROT = 12'h04C, A_IDLE = 12'h050,
        A_THR = 12'h068, A_MASK = 12'h084, A_MCLR = 12'h088, A_MSET = 12'h08C,
        A_PEND = 12'h098, A_LVL = 12'h100;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NSRC-1:0] src = '0;
    logic            irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int prio_sh [NSRC];

    always #2.5 clk = ~clk;

    intc_top i_intc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_lvl   (src),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_lvl(input int n, input int p, input int low);
        prio_sh[n] = p;
        wr(A_LVL + 12'(4 * n), 32'((p << 2) | (low & 3)));
    endtask

    task automatic quiesce();
        src = '0;
        @(negedge clk);
        wr(A_CTRL, 32'h1);
        repeat (2) @(negedge clk);
    endtask

    function automatic int exp_win(input logic [NSRC-1:0] p);
        int best = -1;
        for (int i = 0; i < NSRC; i++)
            if (p[i] && (best < 0 || prio_sh[i] < prio_sh[best])) best = i;
        return best;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0]     d;
        logic [NSRC-1:0] m;
        int              w;
        int              k;
        void'($urandom(32'h1D5A_7C03));
        for (int i = 0; i < NSRC; i++) prio_sh[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        for (int b = 0; b < 3; b++) begin
            rd(A_MASK + 12'(32 * b), d); chk("R1 mask", d, 32'hFFFF_FFFF);
        end
        rd(A_STAT, d);  chk("R1 status", d, 32'h1);
        rd(A_ACT, d);   chk("R1 active", d, 32'h0);
        rd(A_LVL + 12'(4 * 17), d); chk("R1 level", d, 32'h0);
        rd(A_THR, d);   chk("R1 threshold", d, 32'h0);
        rd(A_REV, d);   chk("R1 revision", d, 32'h40);

        // R2 mask ports
        wr(A_MCLR + 12'h20, 32'h0000_00F0);
        rd(A_MASK + 12'h20, d); chk("R2 clear", d, 32'hFFFF_FF0F);
        wr(A_MSET + 12'h20, 32'h0000_0010);
        rd(A_MASK + 12'h20, d); chk("R2 set", d, 32'hFFFF_FF1F);
        wr(A_MASK + 12'h40, 32'h1234_5678);
        rd(A_MASK + 12'h40, d); chk("R2 direct", d, 32'h1234_5678);
        wr(A_MASK + 12'h20, 32'hFFFF_FFFF);
        wr(A_MASK + 12'h40, 32'hFFFF_FFFF);

        // R3 pending view
        wr(A_MCLR, 32'h0000_00FF);
        src[3] = 1'b1; src[40] = 1'b1;
        rd(A_PEND, d);          chk("R3 bank0", d, 32'h0000_0008);
        rd(A_PEND + 12'h20, d); chk("R3 bank1", d, 32'h0);
        rd(A_PEND + 12'h60, d); chk("R3 absent bank", d, 32'h0);
        quiesce();
        wr(A_MASK, 32'hFFFF_FFFF);

        // R10 level registers
        wr(A_LVL + 12'(4 * 17), 32'hFFFF_FFA7);
        rd(A_LVL + 12'(4 * 17), d); chk("R10 level17", d, 32'hA7);
        wr(A_LVL + 12'(4 * 95), 32'h0000_005C);
        rd(A_LVL + 12'(4 * 95), d); chk("R10 level95", d, 32'h5C);

        // R9 side registers
        wr(A_THR, 32'hFF); wr(A_PROT, 32'h1); wr(A_IDLE, 32'h3); wr(A_CFG, 32'h1);
        rd(A_THR, d);  chk("R9 threshold", d, 32'hFF);
        rd(A_PROT, d); chk("R9 protection", d, 32'h1);
        rd(A_IDLE, d); chk("R9 idle", d, 32'h3);
        rd(A_CFG, d);  chk("R9 autoidle", d, 32'h1);
        set_lvl(0, 63, 0);
        wr(A_MASK, 32'hFFFF_FFFE);
        src[0] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R9 irq unaffected", {31'h0, irq}, 32'h1);
        quiesce();

        // random priorities, with frequent ties
        for (int i = 0; i < NSRC; i++) set_lvl(i, int'($urandom_range(0, 7)), int'($urandom));

        // R4 R5 random patterns
        for (int it = 0; it < 60; it++) begin
            logic [NSRC-1:0] s;
            quiesce();
            m = {$urandom | $urandom, $urandom | $urandom, $urandom | $urandom};
            s = {$urandom, $urandom, $urandom};
            for (int b = 0; b < 3; b++) wr(A_MASK + 12'(32 * b), m[32*b +: 32]);
            src = s;
            repeat (4) @(negedge clk);
            w = exp_win(s & ~m);
            chk("R4 irq", {31'h0, irq}, (w >= 0) ? 32'h1 : 32'h0);
            rd(A_PEND + 12'h20, d); chk("R3 random", d, (s & ~m) >> 32 & 32'hFFFF_FFFF);
            if (w >= 0) begin
                rd(A_ACT, d); chk("R5 winner", d, 32'h80 | 32'(w));
                wr(A_CTRL, 32'h1);
                chk("R7 ack drop", {31'h0, irq}, 32'h0);
            end
        end

        // R6 frozen while held
        quiesce();
        wr(A_MASK + 12'h20, 32'hFFFF_FFFF);
        wr(A_MASK + 12'h40, 32'hFFFF_FFFF);
        set_lvl(3, 1, 0); set_lvl(5, 10, 0); set_lvl(9, 2, 0);
        wr(A_MASK, ~32'h0000_0028);
        src[5] = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_ACT, d); chk("R6 first", d, 32'h85);
        src[3] = 1'b1;
        repeat (4) @(negedge clk);
        rd(A_ACT, d); chk("R6 frozen", d, 32'h85);
        chk("R6 irq held", {31'h0, irq}, 32'h1);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_ACT, d); chk("R7 resort", d, 32'h83);

        // R7 stale active cleared by ack
        wr(A_MSET, 32'h0000_0028);
        chk("R7 stale held", {31'h0, irq}, 32'h1);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        chk("R7 stale cleared", {31'h0, irq}, 32'h0);

        // R7 acknowledge coinciding with a new source
        quiesce();
        wr(A_MASK, ~32'h0000_0220);
        src[5] = 1'b1;
        repeat (4) @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_CTRL; bus_wdata = 32'h1;
        src[5] = 1'b0; src[9] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R7 coincide low", {31'h0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R7 coincide irq", {31'h0, irq}, 32'h1);
        rd(A_ACT, d); chk("R7 coincide winner", d, 32'h89);

        // R8 soft reset while held
        wr(A_CFG, 32'h2);
        chk("R8 irq drop", {31'h0, irq}, 32'h0);
        rd(A_STAT, d); chk("R8 busy status", d, 32'h0);
        rd(A_CFG, d);  chk("R8 busy bit", d, 32'h2);
        k = 0;
        while (k < 40) begin
            @(negedge clk);
            k++;
            rd(A_STAT, d);
            if (d[0]) break;
        end
        chk("R8 duration", 32'(k), 32'(NRST));
        rd(A_CFG, d);  chk("R8 cfg cleared", d, 32'h0);
        rd(A_MASK, d); chk("R8 mask reset", d, 32'hFFFF_FFFF);
        rd(A_LVL + 12'(4 * 5), d); chk("R8 level reset", d, 32'h0);
        rd(A_THR, d);  chk("R8 threshold reset", d, 32'h0);
        repeat (3) @(negedge clk);
        chk("R8 irq stays low", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule